// File: doc/BRIEF.md
# Three-Channel Capture/Compare Timer

This block is a 16-bit timer. One counter, set by a period register, is shared by three channels. A prescaler divides the clock before it reaches the counter. The counter can be stopped, left free-running over the full 16-bit range, wrapped at a programmable period, or swept up to the period and back down.

Each channel has its own mode:
- **Capture:** latch the counter value when a synchronized input shows the selected edge.
- **Compare:** set, clear or toggle an output when the counter reaches the channel value.
- **PWM:** raise the output when the counter wraps and drop it on the match.

Compare values are double-buffered so a running PWM waveform never sees a half-updated threshold. All events land in sticky flags that software clears by writing ones. The flags are also exported as a vector so that an interrupt or transfer engine can watch them.

Software reaches everything through a flat register port. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `tri_chan_timer`

## Requirements
- R1: After reset the counter reads 0, the control register reads 0 (stopped), the period reads 0xFFFF, all flags read 0 and every compare output is low.
- R2: Control bits [3:2] select the prescale divide: 0 gives 1, 1 gives 8, 2 gives 32 and 3 gives 128. When the counter is started from a stopped state, it advances exactly floor(N/divide) times in the N clock edges that follow the start write.
- R3: Control bits [1:0] select the run mode: 0 stop, 1 free, 2 modulo, 3 up/down. In free mode the counter steps by one per tick. It wraps from 0xFFFF to 0, and that wrap sets overflow flag bit 0.
- R4: In modulo mode the counter counts 0 up to the period. On the next tick it returns to 0 and sets flag bit 0.
- R5: In up/down mode the counter rises to the period and then falls to 0. Flag bit 0 sets at the turn at the top and again on arrival at 0. Writing the count register always restarts the sweep upward.
- R6: In stop mode the counter holds its value. Writing address 1 loads the counter in any mode.
- R7: A channel whose mode field (config bits [2:0]) is 1 captures the counter after a two-flop synchronizer. Config bits [4:3] select the edge: bit 3 selects rising and bit 4 selects falling. The captured value reads back at the channel value address, and flag bit 1+n sets. Unselected edges leave the value unchanged.
- R8: Compare modes set the output on a match (mode 2), clear it (mode 3) or toggle it (mode 4). A match is the counter stepping onto the active value. Each match sets flag bit 1+n.
- R9: PWM mode (5) drives the output high on the tick that wraps the counter to 0 and low on a match. If both occur on the same tick, the match wins.
- R10: A channel value written while the counter runs is held in a buffer and becomes active on the next wrap to 0. While the counter is stopped the write takes effect at once. The value address reads the active value.
- R11: Writing a one to a flag bit at address 3 clears it, and zeros leave bits alone. A flag event in the same cycle as its clear keeps the bit set.
- R12: Register map: 0 control, 1 count, 2 period, 3 flags, 4+n channel n config, 8+n channel n value. The control, period and config registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| cap_in | input | 3 | Capture inputs, one per channel, asynchronous |
| cmp_out | output | 3 | Compare/PWM outputs, one per channel |
| flag_out | output | 4 | Sticky flags: bit 0 overflow, bit 1+n channel n |

## Verification
The assertions watch the following on every cycle:
- the prescaler never ticks back to back at a divide above one;
- a stopped counter holds;
- a free step adds one and a wrap lands on zero;
- a buffered compare value stays put between wraps;
- a capture stores the count of the previous cycle;
- a PWM match leaves the output low;
- a raised flag stays raised until its own clear.

Only the bench scenarios can show the following:
- the exact count after N edges at each divide;
- the up/down sweep and the agreement of random runs with a reference count;
- the edge selection of capture;
- the cycle at which set, clear, toggle and PWM edges appear;
- the delay of a compare write until the next wrap.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  typedef enum logic [1:0] {
    RUN_STOP = 2'd0,
    RUN_FREE = 2'd1,
    RUN_MOD  = 2'd2,
    RUN_UPDN = 2'd3
  } run_mode_e;

  typedef enum logic [2:0] {
    CH_OFF  = 3'd0,
    CH_CAPT = 3'd1,
    CH_SET  = 3'd2,
    CH_CLR  = 3'd3,
    CH_TGL  = 3'd4,
    CH_PWM  = 3'd5
  } ch_mode_e;

  localparam logic [3:0] ADDR_CTRL = 4'd0;
  localparam logic [3:0] ADDR_CNT  = 4'd1;
  localparam logic [3:0] ADDR_PER  = 4'd2;
  localparam logic [3:0] ADDR_FLAG = 4'd3;
  localparam logic [3:0] ADDR_CFG  = 4'd4;
  localparam logic [3:0] ADDR_VAL  = 4'd8;

  // terminal value of the prescale counter for a divide selector
  function automatic logic [7:0] psc_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    psc_limit = 8'd0;
      2'd1:    psc_limit = 8'd7;
      2'd2:    psc_limit = 8'd31;
      default: psc_limit = 8'd127;
    endcase
  endfunction

  function automatic logic is_compare(input ch_mode_e m);
    is_compare = (m == CH_SET) || (m == CH_CLR) || (m == CH_TGL) || (m == CH_PWM);
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PSC_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [PSC_W-1:0] psc;
  logic [PSC_W-1:0] limit;
  logic             at_end;

  assign limit  = PSC_W'(psc_limit(sel));
  assign at_end = (psc >= limit);
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               psc <= '0;
    else if (!run || at_end)  psc <= '0;
    else                      psc <= psc + 1'b1;
  end

  // a divide above one never yields two ticks in a row
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != 2'd0) |=> (!tick || sel == 2'd0));

endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  run_mode_e    mode,
  input  logic         tick,
  input  logic [W-1:0] period,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         wrap,
  output logic         turn
);

  logic dir_up, dir_nxt;

  always_comb begin
    cnt_nxt = cnt;
    dir_nxt = dir_up;
    wrap    = 1'b0;
    turn    = 1'b0;
    if (tick) begin
      unique case (mode)
        RUN_FREE: begin
          cnt_nxt = cnt + 1'b1;
          wrap    = (cnt == '1);
        end
        RUN_MOD: begin
          if (cnt >= period) begin
            cnt_nxt = '0;
            wrap    = 1'b1;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
        RUN_UPDN: begin
          if (dir_up) begin
            if (cnt >= period) begin
              turn    = 1'b1;
              dir_nxt = 1'b0;
              cnt_nxt = (cnt == '0) ? '0 : cnt - 1'b1;
            end else begin
              cnt_nxt = cnt + 1'b1;
            end
          end else begin
            if (cnt <= W'(1)) begin
              cnt_nxt = '0;
              dir_nxt = 1'b1;
              wrap    = 1'b1;
            end else begin
              cnt_nxt = cnt - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (load) begin
      cnt    <= load_val;
      dir_up <= 1'b1;
    end else begin
      cnt    <= cnt_nxt;
      dir_up <= dir_nxt;
    end
  end

  p_free_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RUN_FREE && tick && !load) |=> (cnt == $past(cnt) + 1'b1));

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !load) |=> (cnt == '0));

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RUN_STOP && !load) |=> $stable(cnt));

endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic         val_we,
  input  logic [W-1:0] wdata,
  input  logic         cap_in,
  input  logic         tick,
  input  logic         running,
  input  logic         reload,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cnt_nxt,
  output logic [W-1:0] cfg_rd,
  output logic [W-1:0] val_rd,
  output logic         out,
  output logic         hit
);

  ch_mode_e     mode;
  logic [1:0]   edge_sel;
  logic [W-1:0] pend, act;
  logic         sync1, sync2, prev;
  logic         rise, fall, cap_evt;
  logic         load_act, match;
  logic [W-1:0] shadow_src, cmp_eff;

  // configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= CH_OFF;
      edge_sel <= 2'b00;
    end else if (cfg_we) begin
      mode     <= ch_mode_e'(wdata[2:0]);
      edge_sel <= wdata[4:3];
    end
  end
  assign cfg_rd = W'({edge_sel, 3'(mode)});

  // input synchronizer and edge detector
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
    end else begin
      sync1 <= cap_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end
  assign rise    = sync2 && !prev;
  assign fall    = !sync2 && prev;
  assign cap_evt = (mode == CH_CAPT) && ((edge_sel[0] && rise) || (edge_sel[1] && fall));

  // buffered compare value
  assign shadow_src = val_we ? wdata : pend;
  assign load_act   = (mode != CH_CAPT) && (reload || !running);
  assign cmp_eff    = load_act ? shadow_src : act;
  assign match      = tick && is_compare(mode) && (cnt_nxt == cmp_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= '0;
    else if (val_we) pend <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        act <= '0;
    else if (cap_evt)  act <= cnt;
    else if (load_act) act <= shadow_src;
  end
  assign val_rd = act;

  // output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out <= 1'b0;
    else if (!is_compare(mode)) out <= 1'b0;
    else if (match) begin
      unique case (mode)
        CH_SET:  out <= 1'b1;
        CH_TGL:  out <= ~out;
        default: out <= 1'b0;
      endcase
    end else if (mode == CH_PWM && reload) out <= 1'b1;
  end

  assign hit = match || cap_evt;

  p_capture_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (act == $past(cnt)));

  p_pwm_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_PWM && match) |=> !out);

  p_buffer_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != CH_CAPT && running && !reload) |=> $stable(act));

endmodule

// File: rtl/tri_chan_timer.sv
`timescale 1ns/1ps
module tri_chan_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CH  = 3,
  parameter int PSC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       reg_addr,
  input  logic             reg_we,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic [N_CH-1:0]  cap_in,
  output logic [N_CH-1:0]  cmp_out,
  output logic [N_CH:0]    flag_out
);

  localparam int FLAG_W = N_CH + 1;

  run_mode_e          run_mode;
  logic [1:0]         psc_sel;
  logic [CNT_W-1:0]   period;
  logic [FLAG_W-1:0]  flags, flag_set, flag_clr;
  logic               tick, running, cnt_load, wrap, turn, ovf;
  logic [CNT_W-1:0]   cnt, cnt_nxt;
  logic [CNT_W-1:0]   cfg_rd [N_CH];
  logic [CNT_W-1:0]   val_rd [N_CH];
  logic [N_CH-1:0]    ch_hit;

  assign running  = (run_mode != RUN_STOP);
  assign cnt_load = reg_we && (reg_addr == ADDR_CNT);
  assign ovf      = wrap || turn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_mode <= RUN_STOP;
      psc_sel  <= 2'd0;
      period   <= '1;
    end else if (reg_we) begin
      if (reg_addr == ADDR_CTRL) begin
        run_mode <= run_mode_e'(reg_wdata[1:0]);
        psc_sel  <= reg_wdata[3:2];
      end
      if (reg_addr == ADDR_PER) period <= reg_wdata;
    end
  end

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk (clk),
    .rst_n (rst_n),
    .run (running),
    .sel (psc_sel),
    .tick (tick)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (run_mode),
    .tick     (tick),
    .period   (period),
    .load     (cnt_load),
    .load_val (reg_wdata),
    .cnt      (cnt),
    .cnt_nxt  (cnt_nxt),
    .wrap     (wrap),
    .turn     (turn)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    tmr_channel #(.W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (reg_we && (reg_addr == ADDR_CFG + 4'(g))),
      .val_we  (reg_we && (reg_addr == ADDR_VAL + 4'(g))),
      .wdata   (reg_wdata),
      .cap_in  (cap_in[g]),
      .tick    (tick),
      .running (running),
      .reload  (wrap),
      .cnt     (cnt),
      .cnt_nxt (cnt_nxt),
      .cfg_rd  (cfg_rd[g]),
      .val_rd  (val_rd[g]),
      .out     (cmp_out[g]),
      .hit     (ch_hit[g])
    );
  end

  // sticky flags, write one to clear, a new event wins
  assign flag_set = {ch_hit, ovf};
  assign flag_clr = (reg_we && reg_addr == ADDR_FLAG) ? reg_wdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | flag_set;
  end
  assign flag_out = flags;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: reg_rdata = CNT_W'({psc_sel, 2'(run_mode)});
      ADDR_CNT:  reg_rdata = cnt;
      ADDR_PER:  reg_rdata = period;
      ADDR_FLAG: reg_rdata = CNT_W'(flags);
      default: begin
        for (int i = 0; i < N_CH; i++) begin
          if (reg_addr == ADDR_CFG + 4'(i)) reg_rdata = cfg_rd[i];
          if (reg_addr == ADDR_VAL + 4'(i)) reg_rdata = val_rd[i];
        end
      end
    endcase
  end

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(reg_we && reg_addr == ADDR_FLAG && reg_wdata[0])) |=> flags[0]);

  p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flags[0]);

endmodule

// File: tb/tri_chan_timer_test.sv
`timescale 1ns/1ps
module tri_chan_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [2:0]  cap_in = 3'd0;
  logic [2:0]  cmp_out;
  logic [3:0]  flag_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  tri_chan_timer uut (
    .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_we (reg_we),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .cap_in (cap_in),
    .cmp_out (cmp_out), .flag_out (flag_out)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // called in the low phase; one rising edge latches the write
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.1;
    d = reg_rdata;
  endtask

  task automatic steps(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int div_of(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 8 : (sel == 2) ? 32 : 128;
  endfunction

  // reference counter: mode 1 free, 2 modulo, 3 up/down
  function automatic logic [15:0] ref_count(input int mode, input logic [15:0] per,
                                            input logic [15:0] start, input int ticks);
    logic [15:0] c = start;
    bit up = 1;
    for (int k = 0; k < ticks; k++) begin
      if (mode == 1) c = c + 16'd1;
      else if (mode == 2) c = (c >= per) ? 16'd0 : c + 16'd1;
      else if (up) begin
        if (c >= per) begin up = 0; c = (c == 0) ? 16'd0 : c - 16'd1; end
        else c = c + 16'd1;
      end else if (c <= 16'd1) begin c = 16'd0; up = 1; end
      else c = c - 16'd1;
    end
    return c;
  endfunction

  task automatic restart(input logic [15:0] per, input logic [15:0] start, input logic [15:0] ctrl);
    wr(4'd0, 16'd0);
    wr(4'd2, per);
    wr(4'd1, start);
    wr(4'd3, 16'hF);
    wr(4'd0, ctrl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd1, d); chk("R1 count", d, 0);
    rd(4'd0, d); chk("R1 ctrl", d, 0);
    rd(4'd2, d); chk("R1 period", d, 16'hFFFF);
    rd(4'd3, d); chk("R1 flags", d, 0);
    chk("R1 cmp_out", cmp_out, 0);

    // R12 readback
    wr(4'd2, 16'h1234); rd(4'd2, d); chk("R12 period", d, 16'h1234);
    wr(4'd5, 16'h001C); rd(4'd5, d); chk("R12 cfg1", d, 16'h001C);
    wr(4'd5, 16'h0000);
    wr(4'd0, 16'h000C); rd(4'd0, d); chk("R12 ctrl", d, 16'h000C);
    wr(4'd0, 16'h0000);

    // R6 stop holds
    wr(4'd1, 16'd5); steps(10); rd(4'd1, d); chk("R6 hold", d, 5);

    // R3 free wrap
    restart(16'd100, 16'hFFFD, 16'h0001);
    steps(2); rd(4'd1, d); chk("R3 at top", d, 16'hFFFF);
    rd(4'd3, d); chk("R3 no flag yet", d[0], 0);
    steps(1); rd(4'd1, d); chk("R3 wrapped", d, 0);
    rd(4'd3, d); chk("R3 overflow flag", d[0], 1);

    // R11 write-one-to-clear
    wr(4'd0, 16'd0);
    wr(4'd3, 16'h0); rd(4'd3, d); chk("R11 zero write keeps", d[0], 1);
    wr(4'd3, 16'h1); rd(4'd3, d); chk("R11 one clears", d[0], 0);

    // R2 prescale
    for (int s = 0; s < 4; s++) begin
      restart(16'd100, 16'd0, 16'(1 | (s << 2)));
      steps(300);
      rd(4'd1, d); chk($sformatf("R2 sel %0d", s), d, 16'(300 / div_of(s)));
    end

    // R4 modulo
    restart(16'd9, 16'd0, 16'h0002);
    steps(9); rd(4'd1, d); chk("R4 at period", d, 9);
    rd(4'd3, d); chk("R4 no flag", d[0], 0);
    steps(1); rd(4'd1, d); chk("R4 wrap", d, 0);
    rd(4'd3, d); chk("R4 flag", d[0], 1);

    // R5 up/down
    restart(16'd4, 16'd0, 16'h0003);
    steps(4); rd(4'd1, d); chk("R5 top", d, 4);
    rd(4'd3, d); chk("R5 no flag", d[0], 0);
    steps(1); rd(4'd1, d); chk("R5 turned", d, 3);
    rd(4'd3, d); chk("R5 turn flag", d[0], 1);
    wr(4'd3, 16'h1);
    steps(2); rd(4'd1, d); chk("R5 bottom", d, 0);
    rd(4'd3, d); chk("R5 bottom flag", d[0], 1);

    // R3 R4 R5 random runs against the reference count
    for (int it = 0; it < 24; it++) begin
      int mode = 1 + int'($urandom % 3);
      int sel  = int'($urandom % 2);
      int n    = int'($urandom % 400);
      logic [15:0] per = 16'(2 + $urandom % 40);
      logic [15:0] st  = (mode == 1) ? 16'($urandom) : 16'($urandom % 32'(per));
      restart(per, st, 16'(mode | (sel << 2)));
      steps(n);
      rd(4'd1, d);
      chk($sformatf("R%0d random mode %0d", mode + 2, mode), d,
          ref_count(mode, per, st, n / div_of(sel)));
    end

    // R8 toggle on channel 0
    wr(4'd0, 16'd0); wr(4'd4, 16'd4); wr(4'd8, 16'd20);
    restart(16'd100, 16'd0, 16'h0002);
    steps(19); chk("R8 toggle before", cmp_out[0], 0);
    steps(1);  chk("R8 toggle at match", cmp_out[0], 1);
    rd(4'd3, d); chk("R8 flag ch0", d[1], 1);

    // R8 set then clear on channel 2
    wr(4'd0, 16'd0); wr(4'd6, 16'd2); wr(4'd10, 16'd7);
    restart(16'd100, 16'd0, 16'h0002);
    steps(6); chk("R8 set before", cmp_out[2], 0);
    steps(1); chk("R8 set", cmp_out[2], 1);
    wr(4'd0, 16'd0); wr(4'd6, 16'd3); wr(4'd10, 16'd3);
    restart(16'd100, 16'd0, 16'h0002);
    steps(2); chk("R8 clear before", cmp_out[2], 1);
    steps(1); chk("R8 clear", cmp_out[2], 0);
    wr(4'd6, 16'd0);

    // R9 PWM on channel 1, then R10 buffered update
    wr(4'd0, 16'd0); wr(4'd5, 16'd5); wr(4'd9, 16'd4);
    restart(16'd9, 16'd0, 16'h0002);
    steps(9);  chk("R9 low before first wrap", cmp_out[1], 0);
    steps(1);  chk("R9 high at wrap", cmp_out[1], 1);
    steps(3);  chk("R9 high before match", cmp_out[1], 1);
    steps(1);  chk("R9 low at match", cmp_out[1], 0);
    wr(4'd9, 16'd7);
    rd(4'd9, d); chk("R10 old value active", d, 4);
    steps(6);
    rd(4'd9, d); chk("R10 new value after wrap", d, 7);
    steps(5); chk("R10 high before new match", cmp_out[1], 1);
    steps(1); chk("R10 low at new match", cmp_out[1], 0);

    // R9 match at zero wins over wrap
    wr(4'd0, 16'd0); wr(4'd9, 16'd0);
    restart(16'd5, 16'd0, 16'h0002);
    steps(12); chk("R9 match wins", cmp_out[1], 0);
    wr(4'd0, 16'd0);

    // R7 capture on channel 1, counter stopped
    wr(4'd5, 16'h0009);
    chk("R7 output idle in capture", cmp_out[1], 0);
    wr(4'd1, 16'h1234); wr(4'd3, 16'hF);
    cap_in[1] = 1'b1; steps(5);
    rd(4'd9, d); chk("R7 rising capture", d, 16'h1234);
    rd(4'd3, d); chk("R7 flag ch1", d[2], 1);
    wr(4'd1, 16'h2222);
    cap_in[1] = 1'b0; steps(5);
    rd(4'd9, d); chk("R7 falling ignored", d, 16'h1234);
    wr(4'd5, 16'h0019); wr(4'd1, 16'h3333);
    cap_in[1] = 1'b1; steps(5);
    rd(4'd9, d); chk("R7 both rising", d, 16'h3333);
    wr(4'd5, 16'h0011); wr(4'd1, 16'h4444);
    cap_in[1] = 1'b0; steps(5);
    rd(4'd9, d); chk("R7 falling only", d, 16'h4444);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule